// File: doc/BRIEF.md
# Nibble-Wide Stack Frame Sequencer

This block is the stack engine of a small 4-bit processor core. Its stack sits in a nibble-wide data memory. The block reaches that memory through a single-port interface and moves one nibble per clock. It accepts one of six commands:

- save or restore an 8-bit register pair;
- save or restore the 4-bit bank-select register;
- save a table-call frame;
- restore an interrupt-return frame.

It keeps the 8-bit stack pointer itself and signals `busy` while a command runs, followed by a one-cycle `done`.

Frames are not laid out as linear words. Each command writes or reads its nibbles at fixed offsets around the stack pointer, in a fixed order. The call frame packs the bank-enable flag and program-counter bit 12 into one nibble. The interrupt-return frame is six nibbles long: four nibbles hold the program counter and flag, and two hold the 8-bit status word. A parameter selects the variant with the smaller program space, in which PC bit 12 is always treated as zero.

The surrounding core supplies the program counter, bank-enable flag, status word, register pair and bank-select value. It picks up the restored values from the output ports once `done` is seen.

Top module: `stack_frame_seq`

## Requirements
- R1: Command code 0 (pair save) writes `pair_in[7:4]` at SP-1 and `pair_in[3:0]` at SP-2, then lowers SP by 2.
- R2: Command code 1 (pair restore) only reads memory. It sets `pair_out` low nibble from address SP and high nibble from SP+1, then raises SP by 2.
- R3: Command code 2 (bank save) writes `bank_in` at SP-1 and 4'h0 at SP-2, then lowers SP by 2. Command code 3 (bank restore) loads `bank_out` from SP+1 and raises SP by 2.
- R4: Command code 4 (table call) writes PC[7:4] at SP-1, PC[3:0] at SP-2 and PC[11:8] at SP-4, then lowers SP by 4.
- R5: The table-call nibble at SP-3 holds the bank-enable flag in bit 3, zeros in bits 2 and 1, and PC bit 12 in bit 0.
- R6: Command code 5 (interrupt return) reads SP..SP+5. It restores PC[11:8] from SP, PC[3:0] from SP+2 and PC[7:4] from SP+3. It restores the flag and PC bit 12 from bits 3 and 0 of SP+1, and the status word as {SP+4, SP+5}. It then raises SP by 6.
- R7: With `SMALL_PC` set, PC bit 12 is written as 0 in the call frame and `pc_out[12]` stays 0 after a return, whatever memory holds.
- R8: A command performs one memory access per cycle, with `busy` high throughout. The access counts are 2, 2, 2, 1, 4 and 6 for codes 0 to 5. `done` is high for exactly one cycle, the cycle after the last access.
- R9: A command is ignored while `busy` is high, including during the `done` cycle. Codes 6 and 7 are also ignored: they start nothing, touch no memory and leave SP unchanged.
- R10: SP arithmetic wraps modulo 256.
- R11: SP and all restored outputs keep their values during access cycles. They change only in the cycle where `done` is high.
- R12: After reset, SP equals `RESET_SP`, all restored outputs are zero, and `busy`, `done` and `mem_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 3 | Command code 0..5 |
| pair_in | input | 8 | Register pair to save |
| bank_in | input | 4 | Bank-select value to save |
| pc_in | input | 13 | Program counter to save |
| mbe_in | input | 1 | Bank-enable flag to save |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| sp | output | 8 | Stack pointer |
| pair_out | output | 8 | Restored register pair |
| bank_out | output | 4 | Restored bank-select value |
| pc_out | output | 13 | Restored program counter |
| mbe_out | output | 1 | Restored bank-enable flag |
| psw_out | output | 8 | Restored status word |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 8 | Memory nibble address |
| mem_wdata | output | 4 | Write nibble |
| mem_rdata | input | 4 | Read nibble, valid in the access cycle |

## Verification
Two events can coincide in one cycle.

- **Last read and commit.** The final nibble of a restore arrives on `mem_rdata` in the same cycle that the whole frame is committed to the outputs and to SP. Every restore sweep therefore checks that the value depending on the last-read nibble (the pair high nibble, or the status low nibble) comes out correct.
- **New request and completion.** A new request can be pending in the cycle the running command completes. On some runs the bench holds `cmd_valid` high with a different, writing command for the whole run, including the `done` cycle. The run must then show the expected access count and SP step, and the full memory image must still equal the bench's reference image.

// File: rtl/stkseq_pkg.sv
package stkseq_pkg;

  localparam int NIB_W     = 4;
  localparam int PC_W      = 13;
  localparam int PSW_W     = 8;
  localparam int MAX_STEPS = 6;
  localparam int STEP_W    = $clog2(MAX_STEPS);
  localparam int SLOTS     = 1 << STEP_W;

  typedef enum logic [2:0] {
    OP_PUSH_PAIR = 3'd0,
    OP_POP_PAIR  = 3'd1,
    OP_PUSH_BANK = 3'd2,
    OP_POP_BANK  = 3'd3,
    OP_TCALL     = 3'd4,
    OP_RETI      = 3'd5
  } seq_op_e;

  function automatic logic op_code_ok(logic [2:0] code);
    return code <= 3'd5;
  endfunction

  // number of memory accesses a command needs
  function automatic logic [STEP_W-1:0] op_steps(seq_op_e op);
    case (op)
      OP_POP_BANK: return STEP_W'(1);
      OP_TCALL:    return STEP_W'(4);
      OP_RETI:     return STEP_W'(6);
      default:     return STEP_W'(2);
    endcase
  endfunction

  function automatic logic op_writes(seq_op_e op);
    return (op == OP_PUSH_PAIR) || (op == OP_PUSH_BANK) || (op == OP_TCALL);
  endfunction

  // signed address offset from SP for a given access step
  function automatic logic signed [3:0] step_offset(seq_op_e op, logic [STEP_W-1:0] step);
    logic signed [3:0] s;
    s = 4'(signed'({1'b0, step}));
    case (op)
      OP_PUSH_PAIR, OP_PUSH_BANK, OP_TCALL: return -(s + 4'sd1);
      OP_POP_BANK:                          return 4'sd1;
      default:                              return s;
    endcase
  endfunction

  // net stack-pointer change once a command completes
  function automatic logic signed [3:0] sp_delta(seq_op_e op);
    case (op)
      OP_PUSH_PAIR, OP_PUSH_BANK: return -4'sd2;
      OP_POP_PAIR, OP_POP_BANK:   return 4'sd2;
      OP_TCALL:                   return -4'sd4;
      default:                    return 4'sd6;
    endcase
  endfunction

endpackage

// File: rtl/stkseq_ctrl.sv
module stkseq_ctrl
  import stkseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  output logic              busy,
  output logic              done,
  output logic              accept,
  output logic              last_access,
  output logic              mem_en,
  output seq_op_e           op_q,
  output logic [STEP_W-1:0] step
);

  typedef enum logic [1:0] {S_IDLE, S_ACCESS, S_FINISH} st_e;
  st_e st;

  assign accept      = (st == S_IDLE) && cmd_valid && op_code_ok(cmd_op);
  assign mem_en      = (st == S_ACCESS);
  assign last_access = mem_en && (step == op_steps(op_q) - STEP_W'(1));
  assign busy        = (st != S_IDLE);
  assign done        = (st == S_FINISH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      step <= '0;
      op_q <= OP_PUSH_PAIR;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          op_q <= seq_op_e'(cmd_op);
          step <= '0;
          st   <= S_ACCESS;
        end
        S_ACCESS: if (last_access) st <= S_FINISH;
                  else step <= step + STEP_W'(1);
        default:  st <= S_IDLE;
      endcase
    end
  end

  AST_DONE_SINGLE:     assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n) done |-> $past(last_access)); // R8
  AST_OP_HELD:         assert property (@(posedge clk) disable iff (!rst_n) ($past(busy) && busy) |-> $stable(op_q)); // R9

endmodule

// File: rtl/stkseq_agu.sv
module stkseq_agu
  import stkseq_pkg::*;
#(
  parameter int SP_W     = 8,
  parameter bit SMALL_PC = 1'b0
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  seq_op_e           op_q,
  input  logic [STEP_W-1:0] step,
  input  logic              mem_en,
  input  logic [SP_W-1:0]   sp,
  input  logic [2*NIB_W-1:0] pair_in,
  input  logic [NIB_W-1:0]  bank_in,
  input  logic [PC_W-1:0]   pc_in,
  input  logic              mbe_in,
  output logic [SP_W-1:0]   mem_addr,
  output logic              mem_we,
  output logic [NIB_W-1:0]  mem_wdata
);

  logic [2*NIB_W-1:0] pair_q;
  logic [NIB_W-1:0]   bank_q;
  logic [PC_W-1:0]    pc_q;
  logic               mbe_q;
  logic signed [3:0]  off;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pair_q <= '0;
      bank_q <= '0;
      pc_q   <= '0;
      mbe_q  <= 1'b0;
    end else if (accept) begin
      pair_q <= pair_in;
      bank_q <= bank_in;
      pc_q   <= {(SMALL_PC ? 1'b0 : pc_in[PC_W-1]), pc_in[PC_W-2:0]};
      mbe_q  <= mbe_in;
    end
  end

  assign off      = step_offset(op_q, step);
  assign mem_addr = sp + {{(SP_W-4){off[3]}}, off};
  assign mem_we   = mem_en && op_writes(op_q);

  always_comb begin
    mem_wdata = '0;
    case (op_q)
      OP_PUSH_PAIR: mem_wdata = (step == '0) ? pair_q[7:4] : pair_q[3:0];
      OP_PUSH_BANK: mem_wdata = (step == '0) ? bank_q : '0;
      OP_TCALL: case (step)
        STEP_W'(0): mem_wdata = pc_q[7:4];
        STEP_W'(1): mem_wdata = pc_q[3:0];
        STEP_W'(2): mem_wdata = {mbe_q, 2'b00, pc_q[12]};
        default:    mem_wdata = pc_q[11:8];
      endcase
      default: mem_wdata = '0;
    endcase
  end

  AST_POP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !op_writes(op_q)) |-> !mem_we); // R2

  generate
    if (SMALL_PC) begin : g_small
      AST_SMALL_FRAME_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && op_q == OP_TCALL && step == STEP_W'(2)) |-> !mem_wdata[0]); // R7
    end
  endgenerate

endmodule

// File: rtl/stkseq_commit.sv
module stkseq_commit
  import stkseq_pkg::*;
#(
  parameter int           SP_W     = 8,
  parameter logic [SP_W-1:0] RESET_SP = '0,
  parameter bit           SMALL_PC = 1'b0
)(
  input  logic               clk,
  input  logic               rst_n,
  input  seq_op_e            op_q,
  input  logic [STEP_W-1:0]  step,
  input  logic               mem_en,
  input  logic               mem_we,
  input  logic               last_access,
  input  logic               done,
  input  logic [NIB_W-1:0]   mem_rdata,
  output logic [SP_W-1:0]    sp,
  output logic [2*NIB_W-1:0] pair_out,
  output logic [NIB_W-1:0]   bank_out,
  output logic [PC_W-1:0]    pc_out,
  output logic               mbe_out,
  output logic [PSW_W-1:0]   psw_out
);

  logic [NIB_W-1:0] nib_q [SLOTS];
  logic [NIB_W-1:0] frame [SLOTS];
  logic             rd_now;
  logic signed [3:0] dlt;

  assign rd_now = mem_en && !mem_we;
  assign dlt    = sp_delta(op_q);

  // frame view: the nibble read in this cycle is merged in directly
  for (genvar k = 0; k < SLOTS; k++) begin : g_frame
    assign frame[k] = (rd_now && step == STEP_W'(k)) ? mem_rdata : nib_q[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < SLOTS; k++) nib_q[k] <= '0;
    end else if (rd_now) begin
      nib_q[step] <= mem_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp       <= RESET_SP;
      pair_out <= '0;
      bank_out <= '0;
      pc_out   <= '0;
      mbe_out  <= 1'b0;
      psw_out  <= '0;
    end else if (last_access) begin
      sp <= sp + {{(SP_W-4){dlt[3]}}, dlt};
      case (op_q)
        OP_POP_PAIR: pair_out <= {frame[1], frame[0]};
        OP_POP_BANK: bank_out <= frame[0];
        OP_RETI: begin
          pc_out  <= {(SMALL_PC ? 1'b0 : frame[1][0]), frame[0], frame[3], frame[2]};
          mbe_out <= frame[1][3];
          psw_out <= {frame[4], frame[5]};
        end
        default: ;
      endcase
    end
  end

  AST_SP_AT_DONE_ONLY: assert property (@(posedge clk) disable iff (!rst_n) !$stable(sp) |-> done); // R11
  AST_OUT_HELD:        assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({pair_out, bank_out, pc_out, mbe_out, psw_out})); // R11
  AST_SP_PARITY:       assert property (@(posedge clk) disable iff (!rst_n) done |-> (sp[0] == $past(sp[0]))); // R10

  generate
    if (SMALL_PC) begin : g_small
      AST_PC_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n) done |-> !pc_out[PC_W-1]); // R7
    end
  endgenerate

endmodule

// File: rtl/stack_frame_seq.sv
module stack_frame_seq
  import stkseq_pkg::*;
#(
  parameter int              SP_W     = 8,
  parameter logic [SP_W-1:0] RESET_SP = '0,
  parameter bit              SMALL_PC = 1'b0
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [2:0]         cmd_op,
  input  logic [2*NIB_W-1:0] pair_in,
  input  logic [NIB_W-1:0]   bank_in,
  input  logic [PC_W-1:0]    pc_in,
  input  logic               mbe_in,
  output logic               busy,
  output logic               done,
  output logic [SP_W-1:0]    sp,
  output logic [2*NIB_W-1:0] pair_out,
  output logic [NIB_W-1:0]   bank_out,
  output logic [PC_W-1:0]    pc_out,
  output logic               mbe_out,
  output logic [PSW_W-1:0]   psw_out,
  output logic               mem_en,
  output logic               mem_we,
  output logic [SP_W-1:0]    mem_addr,
  output logic [NIB_W-1:0]   mem_wdata,
  input  logic [NIB_W-1:0]   mem_rdata
);

  logic              accept;
  logic              last_access;
  seq_op_e           op_q;
  logic [STEP_W-1:0] step;

  stkseq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .busy(busy), .done(done), .accept(accept), .last_access(last_access),
    .mem_en(mem_en), .op_q(op_q), .step(step)
  );

  stkseq_agu #(.SP_W(SP_W), .SMALL_PC(SMALL_PC)) u_agu (
    .clk(clk), .rst_n(rst_n), .accept(accept), .op_q(op_q), .step(step),
    .mem_en(mem_en), .sp(sp), .pair_in(pair_in), .bank_in(bank_in),
    .pc_in(pc_in), .mbe_in(mbe_in), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata)
  );

  stkseq_commit #(.SP_W(SP_W), .RESET_SP(RESET_SP), .SMALL_PC(SMALL_PC)) u_commit (
    .clk(clk), .rst_n(rst_n), .op_q(op_q), .step(step), .mem_en(mem_en),
    .mem_we(mem_we), .last_access(last_access), .done(done), .mem_rdata(mem_rdata),
    .sp(sp), .pair_out(pair_out), .bank_out(bank_out), .pc_out(pc_out),
    .mbe_out(mbe_out), .psw_out(psw_out)
  );

  AST_MEM_EN_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n) mem_en |-> busy); // R8
  AST_NO_ACCESS_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !mem_en); // R8

endmodule

// File: tb/stack_frame_seq_test.sv
module stack_frame_seq_test;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, cmd_valid, mbe_in;
  logic [2:0]  cmd_op;
  logic [7:0]  pair_in;
  logic [3:0]  bank_in;
  logic [12:0] pc_in;
  logic        busy, done, mbe_out, mem_en, mem_we;
  logic [7:0]  sp, pair_out, psw_out, mem_addr;
  logic [3:0]  bank_out, mem_wdata, mem_rdata;
  logic [12:0] pc_out;

  logic        s_valid;
  logic [2:0]  s_op;
  logic        s_busy, s_done, s_mbe_out, s_en, s_we;
  logic [7:0]  s_sp, s_pair_out, s_psw_out, s_addr;
  logic [3:0]  s_bank_out, s_wdata, s_rdata;
  logic [12:0] s_pc_out;

  logic [3:0] mem [256];
  logic [3:0] ref_mem [256];
  logic [3:0] smem [256];
  logic [7:0] ref_sp;
  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  stack_frame_seq uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .pair_in(pair_in), .bank_in(bank_in), .pc_in(pc_in), .mbe_in(mbe_in),
    .busy(busy), .done(done), .sp(sp), .pair_out(pair_out), .bank_out(bank_out),
    .pc_out(pc_out), .mbe_out(mbe_out), .psw_out(psw_out), .mem_en(mem_en),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  stack_frame_seq #(.SMALL_PC(1'b1)) uut_small (
    .clk(clk), .rst_n(rst_n), .cmd_valid(s_valid), .cmd_op(s_op),
    .pair_in(8'h00), .bank_in(4'h0), .pc_in(13'h1ABC), .mbe_in(1'b1),
    .busy(s_busy), .done(s_done), .sp(s_sp), .pair_out(s_pair_out), .bank_out(s_bank_out),
    .pc_out(s_pc_out), .mbe_out(s_mbe_out), .psw_out(s_psw_out), .mem_en(s_en),
    .mem_we(s_we), .mem_addr(s_addr), .mem_wdata(s_wdata), .mem_rdata(s_rdata)
  );

  assign mem_rdata = mem[mem_addr];
  assign s_rdata   = smem[s_addr];
  always @(posedge clk) begin
    if (mem_en && mem_we) mem[mem_addr] <= mem_wdata;
    if (s_en && s_we) smem[s_addr] <= s_wdata;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cmp_mem(input string req);
    int diff = 0, first = -1;
    for (int a = 0; a < 256; a++)
      if (mem[a] !== ref_mem[a]) begin diff++; if (first < 0) first = a; end
    chk(diff == 0, req, "memory image mismatch count (first addr in msg)", diff, 0);
    if (diff != 0) $display("  first differing address %0h", first);
  endtask

  // one command; returns at the negedge of the done cycle
  task automatic run(input logic [2:0] op, input bit jam, input int exp_n);
    int got = 0, guard = 0;
    logic [7:0] old_sp;
    logic [36:0] old_out;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op;
    @(negedge clk);
    if (jam) begin cmd_op = 3'd0; pair_in = 8'h5A; end else cmd_valid = 1'b0;
    old_sp  = sp;
    old_out = {pair_out, bank_out, pc_out, mbe_out, psw_out};
    while (!done && guard < 20) begin
      if (mem_en) got++;
      chk(busy == 1'b1, "R8", "busy during access", busy, 1);
      chk(sp == old_sp && {pair_out, bank_out, pc_out, mbe_out, psw_out} == old_out,
          "R11", "state held during access", sp, old_sp);
      @(negedge clk);
      guard++;
    end
    chk(done == 1'b1 && !mem_en, "R8", "done after last access", done, 1);
    chk(got == exp_n, "R8", "access count", got, exp_n);
    chk(busy == 1'b1, "R9", "busy held in done cycle", busy, 1);
    cmd_valid = 1'b0;
  endtask

  task automatic idle_chk();
    @(negedge clk);
    chk(!done && !busy, "R8", "done lasts one cycle", done, 0);
  endtask

  function automatic logic [7:0] pv(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < 256; a++) begin mem[a] = 4'h0; ref_mem[a] = 4'h0; smem[a] = 4'hF; end
    rst_n = 0; cmd_valid = 0; cmd_op = 0; pair_in = 0; bank_in = 0; pc_in = 0; mbe_in = 0;
    s_valid = 0; s_op = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    ref_sp = 8'h00;
    // R12
    chk(sp == 8'h00 && pair_out == 0 && bank_out == 0 && pc_out == 0 && !mbe_out && psw_out == 0,
        "R12", "reset outputs", sp, 0);
    chk(!busy && !done && !mem_en, "R12", "reset handshake", {busy, done, mem_en}, 0);

    // R9: invalid codes do nothing
    for (int c = 6; c < 8; c++) begin
      cmd_valid = 1; cmd_op = 3'(c);
      @(negedge clk); @(negedge clk);
      chk(!busy && !mem_en && sp == ref_sp, "R9", "invalid code ignored", busy, 0);
      cmd_valid = 0;
    end
    cmp_mem("R9");

    // R1 / R10: pair save sweep, wraps below zero
    for (int i = 0; i < 100; i++) begin
      pair_in = pv(i);
      ref_mem[8'(ref_sp - 8'd1)] = pair_in[7:4];
      ref_mem[8'(ref_sp - 8'd2)] = pair_in[3:0];
      ref_sp = ref_sp - 8'd2;
      run(3'd0, (i % 4) == 0, 2);
      chk(sp == ref_sp, "R1", "SP after pair save", sp, ref_sp);
      if (i == 0) chk(sp == 8'hFE, "R10", "SP wraps from 0", sp, 8'hFE);
      cmp_mem("R1");
      idle_chk();
    end

    // R2: pair restore in reverse
    for (int i = 99; i >= 0; i--) begin
      ref_sp = ref_sp + 8'd2;
      run(3'd1, (i % 5) == 0, 2);
      chk(pair_out == pv(i), "R2", "restored pair", pair_out, pv(i));
      chk(sp == ref_sp, "R2", "SP after pair restore", sp, ref_sp);
      idle_chk();
    end
    cmp_mem("R2");
    chk(sp == 8'h00, "R10", "SP wraps back to 0", sp, 0);

    // R3: bank save/restore
    for (int b = 0; b < 16; b++) begin
      bank_in = 4'(b);
      ref_mem[8'(ref_sp - 8'd1)] = 4'(b);
      ref_mem[8'(ref_sp - 8'd2)] = 4'h0;
      ref_sp = ref_sp - 8'd2;
      run(3'd2, b == 7, 2);
      chk(sp == ref_sp, "R3", "SP after bank save", sp, ref_sp);
      cmp_mem("R3");
      idle_chk();
    end
    for (int b = 15; b >= 0; b--) begin
      ref_sp = ref_sp + 8'd2;
      run(3'd3, b == 3, 1);
      chk(bank_out == 4'(b) && sp == ref_sp, "R3", "restored bank", bank_out, b);
      idle_chk();
    end

    // R4 R5 R6: status pair + call frame, then interrupt return
    for (int i = 0; i < 40; i++) begin
      logic [12:0] pc;
      logic [7:0]  psw;
      logic        f;
      pc  = 13'((i * 1237 + 5) & 8191);
      f   = 1'(i ^ (i >> 1));
      psw = 8'((i * 29 + 3) & 255);
      pair_in = {psw[3:0], psw[7:4]};
      ref_mem[8'(ref_sp - 8'd1)] = psw[3:0];
      ref_mem[8'(ref_sp - 8'd2)] = psw[7:4];
      ref_sp = ref_sp - 8'd2;
      run(3'd0, 0, 2);
      idle_chk();
      pc_in = pc; mbe_in = f;
      ref_mem[8'(ref_sp - 8'd1)] = pc[7:4];
      ref_mem[8'(ref_sp - 8'd2)] = pc[3:0];
      ref_mem[8'(ref_sp - 8'd3)] = {f, 2'b00, pc[12]};
      ref_mem[8'(ref_sp - 8'd4)] = pc[11:8];
      ref_sp = ref_sp - 8'd4;
      run(3'd4, (i % 3) == 0, 4);
      chk(sp == ref_sp, "R4", "SP after table call", sp, ref_sp);
      cmp_mem("R4");
      chk(mem[8'(ref_sp + 8'd1)] == {f, 2'b00, pc[12]}, "R5", "flag nibble",
          mem[8'(ref_sp + 8'd1)], {f, 2'b00, pc[12]});
      idle_chk();
      ref_sp = ref_sp + 8'd6;
      run(3'd5, (i % 3) == 1, 6);
      chk(pc_out == pc, "R6", "restored PC", pc_out, pc);
      chk(mbe_out == f, "R6", "restored flag", mbe_out, f);
      chk(psw_out == psw, "R6", "restored status", psw_out, psw);
      chk(sp == ref_sp, "R6", "SP after return", sp, ref_sp);
      idle_chk();
    end
    cmp_mem("R9");

    // R7: small program space variant, memory preset to all ones
    @(negedge clk); s_valid = 1; s_op = 3'd5;
    @(negedge clk); s_valid = 0;
    repeat (6) @(negedge clk);
    chk(s_done == 1'b1, "R7", "small return done", s_done, 1);
    chk(s_pc_out == 13'h0FFF, "R7", "PC bit 12 ignored", s_pc_out, 13'h0FFF);
    chk(s_mbe_out == 1'b1 && s_psw_out == 8'hFF && s_sp == 8'h06, "R7", "small flag/status/SP",
        {s_mbe_out, s_psw_out, s_sp}, {1'b1, 8'hFF, 8'h06});
    @(negedge clk); s_valid = 1; s_op = 3'd4;
    @(negedge clk); s_valid = 0;
    repeat (4) @(negedge clk);
    chk(s_done == 1'b1 && s_sp == 8'h02, "R7", "small call SP", s_sp, 8'h02);
    chk(smem[8'h03] == 4'h8, "R7", "PC bit 12 written zero", smem[8'h03], 4'h8);
    chk(smem[8'h05] == 4'hB && smem[8'h04] == 4'hC && smem[8'h02] == 4'hA, "R7", "small PC nibbles",
        {smem[8'h05], smem[8'h04], smem[8'h02]}, 12'hBCA);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule